// File: doc/BRIEF.md
# Supply Margining Control Sequencer

This block is the digital control loop of one supply-margining channel. It holds three target codes: a nominal level, a raised level and a lowered level. A mode register selects which target is in force, or switches control off. On each valid sample from an external converter that digitizes the supply output, the block compares the sample with the selected target. If the sample lies outside a programmable tolerance window, the block moves an unsigned trim code one step toward closing the error. A configuration bit sets which way the trim code must move for a given error, so trim pins of either sense can be driven.

Control runs only while a START input is at its programmed active level and a programmable delay has passed since it became active. When a sample first lands inside the window, a ready flag sets and a READY pin of programmable polarity asserts. Correction continues after that point so that the loop tracks load changes. Configuration arrives on a parallel write port, which a lock input can block.

Top module: `margin_ctrl`

## Requirements
- R1: Register writes (wr_en high at a clock edge) use these addresses on wr_addr: 0 nominal target, 1 high target, 2 low target, 3 mode, 4 config, 5 tolerance, 6 start delay. The mode values are 0 off, 1 nominal, 2 high and 3 low. Each non-off mode makes the matching target the loop's set point.
- R2: Config bit 2 selects the trim sense. When it is 0, a sample below the window raises trim_code by one and a sample above the window lowers it by one. When it is 1, both directions are reversed. The trim code changes only on a clock edge where smp_valid is high.
- R3: A sample counts as inside the window when it lies within the tolerance of the target, edges included. A sample inside the window leaves trim_code unchanged.
- R4: Config bit 0 gives START's active level (1 means active high). While start_in is inactive, trim_code does not change.
- R5: Let D be the start delay. After start_in becomes active, the first edge at which trim_code can move is edge D+2, counting the first edge that samples START active as edge 1.
- R6: A valid sample inside the window in a non-off mode sets ready_flag one edge later. Config bit 1 sets the level of ready_out: 1 means ready_out equals ready_flag, 0 means ready_out is its inverse.
- R7: After ready_flag is set, samples outside the window still move trim_code, and ready_flag stays set.
- R8: A change of the mode value clears ready_flag by the second edge after the write.
- R9: While wr_lock is high, writes to any register are ignored.
- R10: trim_code saturates at its all-ones maximum and at 0, and never wraps.
- R11: In mode 0, trim_code holds and ready_flag stays clear.
- R12: After reset: trim_code = 512, ready_flag = 0, ready_out = 0, all targets = 0, mode = off, config = 3'b011, tolerance = 2, start delay = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_lock | input | 1 | Write protect; when high, all writes are blocked |
| wr_addr | input | 3 | Register address |
| wr_data | input | CODE_W (10) | Write data |
| start_in | input | 1 | Start input, with programmable active level |
| smp_valid | input | 1 | A new output-voltage sample is present |
| smp_code | input | CODE_W (10) | Digitized output voltage |
| trim_code | output | TRIM_W (10) | Trim code sent to the trim driver |
| ready_out | output | 1 | Ready pin, with programmable level |
| ready_flag | output | 1 | Ready status bit, active high |

## Verification
The bench drives samples exactly one step outside the tolerance window, and at each edge of it, in both trim senses. A design that used an exclusive window or missed the sense inversion would step the wrong way, or step when it should hold. It counts edges after START becomes active, so a delay counter that is off by one shows up as a trim move one cycle early or late. It writes under lock and reads the result back through the loop's behaviour: a changed mode would clear ready, and a changed target would cause a move. It also drives the trim code into both rails for hundreds of cycles, where a missing saturation would make the code wrap.

// File: rtl/mgn_pkg.sv
package mgn_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_NOM  = 2'd1,
        MODE_HIGH = 2'd2,
        MODE_LOW  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ADR_NOM  = 3'd0,
        ADR_HIGH = 3'd1,
        ADR_LOW  = 3'd2,
        ADR_MODE = 3'd3,
        ADR_CFG  = 3'd4,
        ADR_TOL  = 3'd5,
        ADR_DLY  = 3'd6
    } addr_e;

    typedef struct packed {
        logic trim_inv;
        logic rdy_hi;
        logic start_hi;
    } cfg_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    localparam cfg_t CFG_RST = '{trim_inv: 1'b0, rdy_hi: 1'b1, start_hi: 1'b1};

    function automatic step_e pick_step(input logic below, input logic above,
                                        input logic inv);
        step_e s;
        s = STEP_HOLD;
        if (below)      s = inv ? STEP_DOWN : STEP_UP;
        else if (above) s = inv ? STEP_UP : STEP_DOWN;
        return s;
    endfunction

endpackage

// File: rtl/mgn_regs.sv
module mgn_regs
    import mgn_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int TOL_W  = 6,
    parameter int DLY_W  = 8,
    parameter int TOL_RST = 2,
    parameter int DLY_RST = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_lock,
    input  logic [2:0]             wr_addr,
    input  logic [CODE_W-1:0]      wr_data,
    output logic [2:0][CODE_W-1:0] tgt_o,
    output mode_e                  mode_o,
    output cfg_t                   cfg_o,
    output logic [TOL_W-1:0]       tol_o,
    output logic [DLY_W-1:0]       dly_o
);
    localparam int NUM_TGT = 3;

    logic wr_ok;
    assign wr_ok = wr_en && !wr_lock;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst)
                tgt_o[g] <= '0;
            else if (wr_ok && wr_addr == 3'(g))
                tgt_o[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= MODE_OFF;
            cfg_o  <= CFG_RST;
            tol_o  <= TOL_W'(TOL_RST);
            dly_o  <= DLY_W'(DLY_RST);
        end else if (wr_ok) begin
            case (addr_e'(wr_addr))
                ADR_MODE: mode_o <= mode_e'(wr_data[1:0]);
                ADR_CFG:  cfg_o  <= cfg_t'(wr_data[2:0]);
                ADR_TOL:  tol_o  <= wr_data[TOL_W-1:0];
                ADR_DLY:  dly_o  <= wr_data[DLY_W-1:0];
                default: ;
            endcase
        end
    end

    // R9: a locked write leaves every register untouched
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (rst)
        wr_lock |=> ($stable(mode_o) && $stable(tgt_o) && $stable(cfg_o)
                     && $stable(tol_o) && $stable(dly_o)));
endmodule

// File: rtl/mgn_gate.sv
module mgn_gate #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             start_hi,
    input  logic [DLY_W-1:0] dly,
    output logic             run_o
);
    logic             start_act;
    logic [DLY_W-1:0] cnt_q;

    assign start_act = (start_in == start_hi);

    always_ff @(posedge clk) begin
        if (rst || !start_act) begin
            cnt_q <= '0;
            run_o <= 1'b0;
        end else if (cnt_q >= dly) begin
            run_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: an inactive START stops the loop at the next edge
    a_r4_inactive_stops: assert property (@(posedge clk) disable iff (rst)
        (start_in != start_hi) |=> !run_o);
endmodule

// File: rtl/mgn_loop.sv
module mgn_loop
    import mgn_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int TRIM_W    = 10,
    parameter int TOL_W     = 6,
    parameter int TRIM_INIT = 512
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run_i,
    input  mode_e                  mode_i,
    input  logic [2:0][CODE_W-1:0] tgt_i,
    input  logic                   trim_inv,
    input  logic [TOL_W-1:0]       tol_i,
    input  logic                   smp_valid,
    input  logic [CODE_W-1:0]      smp_code,
    output logic [TRIM_W-1:0]      trim_o,
    output logic                   ready_o
);
    localparam int           EXT_W    = CODE_W + 1;
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

    logic [CODE_W-1:0] target;
    logic [EXT_W-1:0]  smp_x, tgt_x, tol_x;
    logic              below, above, act;
    step_e             step;
    mode_e             mode_prev_q;

    always_comb begin
        case (mode_i)
            MODE_HIGH: target = tgt_i[1];
            MODE_LOW:  target = tgt_i[2];
            default:   target = tgt_i[0];
        endcase
    end

    assign smp_x = EXT_W'(smp_code);
    assign tgt_x = EXT_W'(target);
    assign tol_x = EXT_W'(tol_i);
    assign below = (smp_x + tol_x) < tgt_x;
    assign above = smp_x > (tgt_x + tol_x);
    assign step  = pick_step(below, above, trim_inv);
    assign act   = run_i && (mode_i != MODE_OFF) && smp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_o <= TRIM_W'(TRIM_INIT);
        end else if (act) begin
            if (step == STEP_UP && trim_o != TRIM_MAX)
                trim_o <= trim_o + 1'b1;
            else if (step == STEP_DOWN && trim_o != '0)
                trim_o <= trim_o - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_prev_q <= MODE_OFF;
            ready_o     <= 1'b0;
        end else begin
            mode_prev_q <= mode_i;
            if (!run_i || mode_i == MODE_OFF || mode_i != mode_prev_q)
                ready_o <= 1'b0;
            else if (act && step == STEP_HOLD)
                ready_o <= 1'b1;
        end
    end

    // R2: the trim code moves by at most one LSB per edge
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (trim_o != $past(trim_o)) |->
            (trim_o == $past(trim_o) + 1'b1 || trim_o == $past(trim_o) - 1'b1));

    // R10: no wrap at either rail
    a_r10_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
        ($past(trim_o) == TRIM_MAX) |-> (trim_o != '0));
    a_r10_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
        ($past(trim_o) == '0) |-> (trim_o != TRIM_MAX));

    // R4: the trim code holds while the gate is closed
    a_r4_gated_hold: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(trim_o));

    // R11: control off holds the trim code
    a_r11_off_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OFF) |=> ($stable(trim_o) && !ready_o));

    // R8: a mode change drops ready on the following edge
    a_r8_mode_clears: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_i) |=> !ready_o);
endmodule

// File: rtl/margin_ctrl.sv
module margin_ctrl
    import mgn_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int TRIM_W    = 10,
    parameter int TOL_W     = 6,
    parameter int DLY_W     = 8,
    parameter int TRIM_INIT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [2:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              start_in,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic [TRIM_W-1:0] trim_code,
    output logic              ready_out,
    output logic              ready_flag
);
    logic [2:0][CODE_W-1:0] tgt;
    mode_e                  mode;
    cfg_t                   cfg;
    logic [TOL_W-1:0]       tol;
    logic [DLY_W-1:0]       dly;
    logic                   run;

    mgn_regs #(.CODE_W(CODE_W), .TOL_W(TOL_W), .DLY_W(DLY_W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lock(wr_lock),
        .wr_addr(wr_addr), .wr_data(wr_data), .tgt_o(tgt), .mode_o(mode),
        .cfg_o(cfg), .tol_o(tol), .dly_o(dly)
    );

    mgn_gate #(.DLY_W(DLY_W)) i_gate (
        .clk(clk), .rst(rst), .start_in(start_in), .start_hi(cfg.start_hi),
        .dly(dly), .run_o(run)
    );

    mgn_loop #(.CODE_W(CODE_W), .TRIM_W(TRIM_W), .TOL_W(TOL_W),
               .TRIM_INIT(TRIM_INIT)) i_loop (
        .clk(clk), .rst(rst), .run_i(run), .mode_i(mode), .tgt_i(tgt),
        .trim_inv(cfg.trim_inv), .tol_i(tol), .smp_valid(smp_valid),
        .smp_code(smp_code), .trim_o(trim_code), .ready_o(ready_flag)
    );

    assign ready_out = cfg.rdy_hi ? ready_flag : !ready_flag;
endmodule

// File: tb/test_margin_ctrl.sv
`timescale 1ns/1ps
module test_margin_ctrl;
    localparam int CW = 10;
    localparam int TW = 10;
    localparam int NV = 13;
    // columns: mode, trim sense, sample, expected step (0 hold, 1 up, 2 down)
    localparam int VEC [NV][4] = '{
        '{1, 0, 290, 1}, '{1, 0, 310, 2}, '{1, 0, 302, 0}, '{1, 0, 297, 1},
        '{2, 0, 390, 1}, '{2, 0, 402, 0}, '{2, 1, 390, 2}, '{3, 0, 210, 2},
        '{3, 1, 210, 1}, '{3, 1, 198, 0}, '{0, 0, 0, 0},   '{1, 1, 298, 0},
        '{1, 1, 303, 1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, wr_lock = 1'b0, start_in = 1'b0, smp_valid = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0, smp_code = '0;
    logic [TW-1:0] trim_code;
    logic ready_out, ready_flag;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    margin_ctrl i_margin_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lock(wr_lock),
        .wr_addr(wr_addr), .wr_data(wr_data), .start_in(start_in),
        .smp_valid(smp_valid), .smp_code(smp_code), .trim_code(trim_code),
        .ready_out(ready_out), .ready_flag(ready_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wreg(input int adr, input int val);
        wr_en = 1'b1; wr_addr = 3'(adr); wr_data = CW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int val);
        smp_valid = 1'b1; smp_code = CW'(val);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 trim", int'(trim_code), 512);
        chk("R12 flag", int'(ready_flag), 0);
        chk("R12 pin", int'(ready_out), 0);

        // R1: load targets, no start delay
        wreg(0, 300); wreg(1, 400); wreg(2, 200); wreg(6, 0);
        start_in = 1'b1;
        idle(3);

        // R1 R2 R3 R11: table walk
        for (int v = 0; v < NV; v++) begin
            wreg(4, (VEC[v][1] << 2) | 3);
            wreg(3, VEC[v][0]);
            t0 = int'(trim_code);
            pulse(VEC[v][2]);
            chk($sformatf("R2 vec%0d", v), int'(trim_code),
                VEC[v][3] == 1 ? t0 + 1 : (VEC[v][3] == 2 ? t0 - 1 : t0));
        end

        // R5: delay 3 -> first move on edge 5
        wreg(4, 3); start_in = 1'b0; wreg(6, 3); wreg(3, 1);
        idle(2);
        smp_valid = 1'b1; smp_code = 100;
        start_in = 1'b1;
        t0 = int'(trim_code);
        idle(4);
        chk("R5 before delay", int'(trim_code), t0);
        idle(1);
        chk("R5 first move", int'(trim_code), t0 + 1);
        smp_valid = 1'b0;

        // R4: active-low START
        wreg(4, 2);
        idle(6);
        t0 = int'(trim_code);
        smp_valid = 1'b1; smp_code = 100;
        idle(5);
        smp_valid = 1'b0;
        chk("R4 inactive hold", int'(trim_code), t0);
        start_in = 1'b0;
        idle(6);
        pulse(100);
        chk("R4 active low moves", int'(trim_code), t0 + 1);
        wreg(4, 3); start_in = 1'b1; wreg(6, 0);
        idle(3);

        // R3 R6: inside window sets ready
        t0 = int'(trim_code);
        pulse(302);
        chk("R3 hold at edge", int'(trim_code), t0);
        chk("R6 flag set", int'(ready_flag), 1);
        chk("R6 pin high", int'(ready_out), 1);
        wreg(4, 1);
        chk("R6 pin low level", int'(ready_out), 0);
        wreg(4, 3);

        // R7: correction continues after ready
        pulse(295);
        chk("R7 moves", int'(trim_code), t0 + 1);
        chk("R7 flag kept", int'(ready_flag), 1);

        // R8: mode change clears ready
        wreg(3, 2);
        idle(1);
        chk("R8 cleared", int'(ready_flag), 0);
        pulse(400);
        chk("R6 ready on new target", int'(ready_flag), 1);

        // R9: locked writes ignored
        wr_lock = 1'b1;
        wreg(0, 700); wreg(3, 1);
        wr_lock = 1'b0;
        t0 = int'(trim_code);
        pulse(400);
        chk("R9 mode kept", int'(ready_flag), 1);
        chk("R9 no move", int'(trim_code), t0);
        wreg(3, 1);
        pulse(300);
        chk("R9 nominal kept", int'(trim_code), t0);

        // R11: off mode
        wreg(3, 0);
        pulse(0);
        chk("R11 hold", int'(trim_code), t0);
        chk("R11 no ready", int'(ready_flag), 0);

        // R10: saturation at both rails
        wreg(1, 1023); wreg(5, 0); wreg(3, 2);
        smp_valid = 1'b1; smp_code = 0;
        idle(600);
        chk("R10 top rail", int'(trim_code), 1023);
        smp_valid = 1'b0;
        wreg(2, 0); wreg(3, 3);
        smp_valid = 1'b1; smp_code = 1023;
        idle(1100);
        chk("R10 bottom rail", int'(trim_code), 0);
        smp_valid = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule